// File: doc/BRIEF.md
# Multi-Stream Time-Slot Payload Map

This block keeps the table that assigns each of the 64 time slots of a multi-stream link frame to a 4-bit payload identifier, and turns it into a per-slot stream select for the framing logic. Software programs the table and the per-stream identifiers through a 32-bit word-addressed register port. The framer presents a slot index each cycle and receives, one cycle later, the payload identifier, the stream number that owns the slot, or an idle flag when nobody does.

The table is double-buffered. Register writes land in a shadow copy. The copy the framer uses is refreshed from the shadow either at the start of each multi-stream transport packet (a one-cycle `mtp_start` pulse) or at once when software writes the force bit. When multi-stream mode is off, every slot is handed to stream 0 as in single-stream framing.

Top module: `mst_slot_map`

## Requirements
- R1: After reset, every shadow and active entry, every stream identifier and the mode bit are 0, and the lookup outputs show `out_vld`=0, `out_idle`=1, `out_stream`=0, `out_pid`=0.
- R2: The shadow table is eight 32-bit words at addresses 0xA2 to 0xA9. Slot k is held in the word at 0xA2+k/8, bits [4*(k%8)+3 : 4*(k%8)]. A read returns the written word on `reg_rd_data` one cycle after `reg_rd_en`, and `reg_rd_data` is 0 in any cycle that follows no read.
- R3: A shadow write alone does not change what the lookup reports.
- R4: An `mtp_start` pulse copies the whole shadow table into the active table at that clock edge.
- R5: The control word at 0xA0 holds the mode bit in bit 0 and a force bit in bit 1. Writing bit 1 as 1 copies the shadow table into the active table at the edge of that write. Bit 1 always reads as 0, and bits 31:2 read as 0.
- R6: In multi-stream mode, a slot other than 0 whose active entry is nonzero and equal to the identifier of stream s reports `out_idle`=0, `out_stream`=s and `out_pid`=entry. When several streams hold that identifier, the lowest stream number wins.
- R7: In multi-stream mode, a slot whose entry is 0 or equal to no stream identifier reports `out_idle`=1, `out_stream`=0 and `out_pid`=0.
- R8: In multi-stream mode, slot 0 always reports idle, whatever its entry holds.
- R9: With the mode bit 0, every slot (slot 0 included) reports `out_idle`=0, `out_stream`=0 and `out_pid`=0.
- R10: Lookup outputs are registered. `out_vld` equals `slot_vld` of the previous cycle, and the other outputs reflect the slot index, table, identifiers and mode of that cycle.
- R11: Writes to any address other than 0xA0 to 0xA9 change nothing, and reads from such addresses return 0.
- R12: The identifier word at 0xA1 holds stream 0 to 3 in bits [3:0], [7:4], [11:8] and [15:12]. Identifier changes take effect without a commit, and bits 31:16 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read word address |
| reg_rd_data | output | 32 | Read data, one cycle after the strobe |
| mtp_start | input | 1 | Transport packet boundary pulse that commits the shadow table |
| slot_vld | input | 1 | Slot index valid |
| slot_idx | input | 6 | Slot being framed |
| out_vld | output | 1 | Lookup result valid |
| out_idle | output | 1 | Slot is idle or unallocated |
| out_stream | output | 2 | Stream that owns the slot |
| out_pid | output | 4 | Payload identifier of the slot |

## Verification
The bench builds the block with its default parameters: 64 slots of 4 bits, four streams and 32-bit words. This makes the full slot range, the last word and the slot 63 nibble at bits 31:28 reachable, and lets the identifier space hold duplicated stream identifiers. Random table contents are drawn from a small identifier range, so matches, duplicated identifiers, zero entries and unmatched entries all occur often. Random commits, forced updates and mode toggles are interleaved, so the shadow and active copies drift apart and the lookup shows which copy is in force.

// File: rtl/mst_slot_pkg.sv
package mst_slot_pkg;

    localparam int PID_W       = 4;
    localparam int NUM_SLOTS   = 64;
    localparam int NUM_STREAMS = 4;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;

    localparam int SLOTS_PER_WORD = REG_W / PID_W;
    localparam int TBL_WORDS      = NUM_SLOTS / SLOTS_PER_WORD;
    localparam int TBL_IDX_W      = $clog2(TBL_WORDS);
    localparam int SLOT_W         = $clog2(NUM_SLOTS);
    localparam int STREAM_W       = $clog2(NUM_STREAMS);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'hA0;
    localparam logic [ADDR_W-1:0] ADDR_IDS  = 8'hA1;
    localparam logic [ADDR_W-1:0] ADDR_TBL0 = 8'hA2;

    localparam int CTRL_MODE_BIT  = 0;
    localparam int CTRL_FORCE_BIT = 1;

    typedef logic [PID_W-1:0] pid_t;

    typedef struct packed {
        logic                vld;
        logic                idle;
        logic [STREAM_W-1:0] stream;
        pid_t                pid;
    } slot_res_t;

    localparam slot_res_t RES_RESET = '{vld: 1'b0, idle: 1'b1, stream: '0, pid: '0};

    function automatic logic in_table(input logic [ADDR_W-1:0] a);
        return (a >= ADDR_TBL0) && (a < ADDR_W'(ADDR_TBL0 + TBL_WORDS));
    endfunction

endpackage

// File: rtl/mst_slot_regs.sv
module mst_slot_regs
    import mst_slot_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [REG_W-1:0]                      wr_data,
    input  logic                                  rd_en,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [REG_W-1:0]                      rd_data,
    output logic                                  mode_mst,
    output logic                                  force_upd,
    output logic [NUM_STREAMS-1:0][PID_W-1:0]     stream_ids,
    output logic [TBL_WORDS-1:0][REG_W-1:0]       shadow
);

    logic [REG_W-1:0]      rd_mux;
    logic [ADDR_W-1:0]     rd_off;
    logic                  wr_ctrl;
    logic                  wr_ids;

    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_ids    = wr_en && (wr_addr == ADDR_IDS);
    assign force_upd = wr_ctrl && wr_data[CTRL_FORCE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_mst <= 1'b0;
        end else if (wr_ctrl) begin
            mode_mst <= wr_data[CTRL_MODE_BIT];
        end
    end

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_ids
        always_ff @(posedge clk) begin
            if (rst) begin
                stream_ids[s] <= '0;
            end else if (wr_ids) begin
                stream_ids[s] <= wr_data[s*PID_W +: PID_W];
            end
        end
    end

    for (genvar w = 0; w < TBL_WORDS; w++) begin : g_shadow
        localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(ADDR_TBL0 + w);
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[w] <= '0;
            end else if (wr_en && (wr_addr == WORD_ADDR)) begin
                shadow[w] <= wr_data;
            end
        end
    end

    assign rd_off = rd_addr - ADDR_TBL0;

    always_comb begin
        rd_mux = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_mux[CTRL_MODE_BIT] = mode_mst;
        end else if (rd_addr == ADDR_IDS) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                rd_mux[s*PID_W +: PID_W] = stream_ids[s];
            end
        end else if (in_table(rd_addr)) begin
            rd_mux = shadow[rd_off[TBL_IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/mst_slot_table.sv
module mst_slot_table
    import mst_slot_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit,
    input  logic [TBL_WORDS-1:0][REG_W-1:0]   shadow,
    output logic [TBL_WORDS-1:0][REG_W-1:0]   active,
    output logic [NUM_SLOTS-1:0][PID_W-1:0]   entries
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (commit) begin
            active <= shadow;
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam int WORD = k / SLOTS_PER_WORD;
        localparam int LSB  = (k % SLOTS_PER_WORD) * PID_W;
        assign entries[k] = active[WORD][LSB +: PID_W];
    end

endmodule

// File: rtl/mst_slot_lookup.sv
module mst_slot_lookup
    import mst_slot_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              slot_vld,
    input  logic [SLOT_W-1:0]                 slot_idx,
    input  logic                              mode_mst,
    input  logic [NUM_SLOTS-1:0][PID_W-1:0]   entries,
    input  logic [NUM_STREAMS-1:0][PID_W-1:0] stream_ids,
    output slot_res_t                         res
);

    pid_t                 entry;
    logic [NUM_STREAMS-1:0] hit;
    logic                 any_hit;
    logic [STREAM_W-1:0]  win;
    slot_res_t            res_nx;

    assign entry = entries[slot_idx];

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_match
        assign hit[s] = (entry != '0) && (stream_ids[s] == entry);
    end

    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
            if (hit[s]) begin
                any_hit = 1'b1;
                win     = STREAM_W'(s);
            end
        end
    end

    always_comb begin
        res_nx     = RES_RESET;
        res_nx.vld = slot_vld;
        if (!mode_mst) begin
            res_nx.idle = 1'b0;
        end else if ((slot_idx != '0) && any_hit) begin
            res_nx.idle   = 1'b0;
            res_nx.stream = win;
            res_nx.pid    = entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= RES_RESET;
        end else begin
            res <= res_nx;
        end
    end

endmodule

// File: rtl/mst_slot_map.sv
module mst_slot_map
    import mst_slot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_wr_addr,
    input  logic [REG_W-1:0]     reg_wr_data,
    input  logic                 reg_rd_en,
    input  logic [ADDR_W-1:0]    reg_rd_addr,
    output logic [REG_W-1:0]     reg_rd_data,
    input  logic                 mtp_start,
    input  logic                 slot_vld,
    input  logic [SLOT_W-1:0]    slot_idx,
    output logic                 out_vld,
    output logic                 out_idle,
    output logic [STREAM_W-1:0]  out_stream,
    output logic [PID_W-1:0]     out_pid
);

    logic                              mode_mst;
    logic                              force_upd;
    logic                              commit;
    logic [NUM_STREAMS-1:0][PID_W-1:0] stream_ids;
    logic [TBL_WORDS-1:0][REG_W-1:0]   shadow;
    logic [TBL_WORDS-1:0][REG_W-1:0]   active;
    logic [NUM_SLOTS-1:0][PID_W-1:0]   entries;
    slot_res_t                         res;

    assign commit = force_upd | mtp_start;

    mst_slot_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_en      (reg_rd_en),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .mode_mst   (mode_mst),
        .force_upd  (force_upd),
        .stream_ids (stream_ids),
        .shadow     (shadow)
    );

    mst_slot_table u_table (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .shadow  (shadow),
        .active  (active),
        .entries (entries)
    );

    mst_slot_lookup u_lookup (
        .clk        (clk),
        .rst        (rst),
        .slot_vld   (slot_vld),
        .slot_idx   (slot_idx),
        .mode_mst   (mode_mst),
        .entries    (entries),
        .stream_ids (stream_ids),
        .res        (res)
    );

    assign out_vld    = res.vld;
    assign out_idle   = res.idle;
    assign out_stream = res.stream;
    assign out_pid    = res.pid;

endmodule

// File: rtl/mst_slot_map_chk.sv
module mst_slot_map_chk
    import mst_slot_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_rd_en,
    input logic [ADDR_W-1:0]               reg_rd_addr,
    input logic [REG_W-1:0]                reg_rd_data,
    input logic                            mtp_start,
    input logic                            slot_vld,
    input logic [SLOT_W-1:0]               slot_idx,
    input logic                            out_vld,
    input logic                            out_idle,
    input logic [STREAM_W-1:0]             out_stream,
    input logic [PID_W-1:0]                out_pid,
    input logic                            mode_mst,
    input logic                            commit,
    input logic [TBL_WORDS-1:0][REG_W-1:0] shadow,
    input logic [TBL_WORDS-1:0][REG_W-1:0] active
);

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld |=> out_vld);

    // R10
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_vld |=> !out_vld);

    // R8
    slot0_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && mode_mst && (slot_idx == '0)) |=> out_idle);

    // R9
    single_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && !mode_mst) |=> (!out_idle && (out_stream == '0) && (out_pid == '0)));

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    // R4
    mtp_commit_chk: assert property (@(posedge clk) disable iff (rst)
        mtp_start |=> (active == $past(shadow)));

    // R5
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && (reg_rd_addr == ADDR_CTRL)) |=> (reg_rd_data[REG_W-1:1] == '0));

    // R7
    idle_pid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_idle |-> ((out_pid == '0) && (out_stream == '0)));

endmodule

bind mst_slot_map mst_slot_map_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .mtp_start   (mtp_start),
    .slot_vld    (slot_vld),
    .slot_idx    (slot_idx),
    .out_vld     (out_vld),
    .out_idle    (out_idle),
    .out_stream  (out_stream),
    .out_pid     (out_pid),
    .mode_mst    (mode_mst),
    .commit      (commit),
    .shadow      (shadow),
    .active      (active)
);

// File: tb/mst_slot_map_tb.sv
module mst_slot_map_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mtp_start = 1'b0;
    logic        slot_vld = 1'b0;
    logic [5:0]  slot_idx = '0;
    logic        out_vld;
    logic        out_idle;
    logic [1:0]  out_stream;
    logic [3:0]  out_pid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0] m_sh  [64];
    logic [3:0] m_act [64];
    logic [3:0] m_id  [4];
    bit         m_mst;

    always #4 clk = ~clk;

    mst_slot_map u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mtp_start(mtp_start), .slot_vld(slot_vld), .slot_idx(slot_idx),
        .out_vld(out_vld), .out_idle(out_idle), .out_stream(out_stream), .out_pid(out_pid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'hA0) r[0] = m_mst;
        else if (a == 8'hA1) r = {16'h0, m_id[3], m_id[2], m_id[1], m_id[0]};
        else if (a >= 8'hA2 && a <= 8'hA9)
            for (int i = 0; i < 8; i++) r[4*i +: 4] = m_sh[(a - 8'hA2) * 8 + i];
        return r;
    endfunction

    function automatic logic [6:0] model_look(input int slot);
        logic [3:0] e;
        if (!m_mst) return {1'b0, 2'd0, 4'd0};
        if (slot == 0) return {1'b1, 2'd0, 4'd0};
        e = m_act[slot];
        if (e == 4'd0) return {1'b1, 2'd0, 4'd0};
        for (int s = 0; s < 4; s++)
            if (m_id[s] == e) return {1'b0, 2'(s), e};
        return {1'b1, 2'd0, 4'd0};
    endfunction

    task automatic commit_model();
        for (int k = 0; k < 64; k++) m_act[k] = m_sh[k];
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        if (a == 8'hA0) begin
            m_mst = d[0];
            if (d[1]) commit_model();
        end else if (a == 8'hA1) begin
            for (int s = 0; s < 4; s++) m_id[s] = d[4*s +: 4];
        end else if (a >= 8'hA2 && a <= 8'hA9) begin
            for (int i = 0; i < 8; i++) m_sh[(a - 8'hA2) * 8 + i] = d[4*i +: 4];
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_rd_addr = a;
        @(posedge clk); #1;
        reg_rd_en = 1'b0;
        check(req, reg_rd_data, model_read(a));
    endtask

    task automatic mtp();
        @(negedge clk);
        mtp_start = 1'b1;
        @(posedge clk); #1;
        mtp_start = 1'b0;
        commit_model();
    endtask

    task automatic look(input int slot, input string req);
        logic [6:0] e;
        @(negedge clk);
        slot_vld = 1'b1; slot_idx = 6'(slot);
        @(posedge clk); #1;
        slot_vld = 1'b0;
        e = model_look(slot);
        check({req, " vld"}, 32'(out_vld), 32'd1);
        check(req, {25'd0, out_idle, out_stream, out_pid}, {25'd0, e});
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] w;
        for (int i = 0; i < 8; i++) w[4*i +: 4] = 4'($urandom_range(0, 6));
        return w;
    endfunction

    initial begin
        #1500000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k < 64; k++) begin m_sh[k] = '0; m_act[k] = '0; end
        for (int s = 0; s < 4; s++) m_id[s] = '0;
        m_mst = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 out_vld", 32'(out_vld), 32'd0);
        check("R1 out_idle", 32'(out_idle), 32'd1);
        check("R1 out", {out_stream, out_pid}, 32'd0);
        check("R2 rd_data idle", reg_rd_data, 32'd0);
        rd(8'hA0, "R1 ctrl");
        rd(8'hA1, "R1 ids");
        rd(8'hA9, "R1 table");
        // R9 single-stream mode
        look(5, "R9 slot5");
        look(0, "R9 slot0");
        // R12 identifiers, upper bits dropped
        wr(8'hA1, 32'hFFFF_4321);
        rd(8'hA1, "R12 ids");
        check("R12 upper", reg_rd_data[31:16], 32'd0);
        // R2 table layout
        wr(8'hA2, 32'h0000_4321);
        rd(8'hA2, "R2 word0");
        wr(8'hA0, 32'h1);
        // R3 shadow not yet active
        look(1, "R3 before commit");
        check("R3 idle", 32'(out_idle), 32'd1);
        // R4 commit on packet boundary
        mtp();
        look(1, "R4 slot1");
        check("R6 slot1 stream", {out_idle, out_stream, out_pid}, {1'b0, 2'd1, 4'd2});
        look(0, "R8 slot0");
        check("R8 idle", 32'(out_idle), 32'd1);
        look(4, "R7 zero entry");
        // R5 forced update, slot 63 at word 7 bits 31:28
        wr(8'hA9, 32'h9000_0000);
        look(63, "R3 slot63 pre");
        wr(8'hA0, 32'h3);
        look(63, "R7 unmatched");
        rd(8'hA0, "R5 force reads 0");
        check("R5 ctrl", reg_rd_data, 32'd1);
        // R6 priority and immediate identifier update
        wr(8'hA1, 32'h0000_9222);
        look(63, "R12 immediate");
        check("R6 slot63", {out_idle, out_stream, out_pid}, {1'b0, 2'd3, 4'd9});
        look(1, "R6 lowest wins");
        check("R6 dup", 32'(out_stream), 32'd0);
        // R11 unmapped addresses
        wr(8'hAA, 32'hFFFF_FFFF);
        wr(8'h9F, 32'hFFFF_FFFF);
        rd(8'hAA, "R11 rd AA");
        rd(8'h9F, "R11 rd 9F");
        rd(8'hA2, "R11 table intact");
        rd(8'hA0, "R11 ctrl intact");
        look(1, "R11 lookup intact");
        // R10 valid drops
        @(negedge clk);
        @(posedge clk); #1;
        check("R10 vld low", 32'(out_vld), 32'd0);
        check("R2 rd_data no read", reg_rd_data, 32'd0);
        // R9 back to single stream
        wr(8'hA0, 32'h0);
        look(1, "R9 off");
        // random phase
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0, 1: wr(8'(8'hA2 + $urandom_range(0, 7)), rand_word());
                2: wr(8'hA1, {16'h0, 4'($urandom_range(0, 6)), 4'($urandom_range(0, 6)),
                              4'($urandom_range(0, 6)), 4'($urandom_range(0, 6))});
                3: wr(8'hA0, {30'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0)});
                4: mtp();
                5: rd(8'(8'h9F + $urandom_range(0, 12)), "R2 random read");
                default: look($urandom_range(0, 63), "R6 random lookup");
            endcase
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule